// File: doc/BRIEF.md
# Quadrature Counter Setup and Readout Sequencer

This block is a host-side SPI master that runs one fixed script against a remote 32-bit quadrature counter. A single pulse on `start` opens a select window in which both mode registers of the counter are written. The block then keeps the link idle for a programmable number of clock cycles and opens a second window that reads the live count back.

All transfers are full duplex, use SPI mode 0 (clock idle low, data sampled on the rising edge) and send the most significant bit first. During the read window the master sends a read-count command followed by four zero filler bytes. The reply that arrives during the command byte is dropped. The four replies that arrive during the filler bytes are packed, first byte highest, into a 32-bit result. A one-cycle `count_valid` strobe marks the new result.

The SCLK half period (`HALF_DIV` clock cycles) and the pause between the two windows (`WAIT_CYCLES` clock cycles) are parameters. The default pause is one second at 100 MHz.

Top module: `spi_cnt_seq`

## Requirements
- R1: The first select window carries exactly four bytes on MOSI, in this order: 0x88, 0x03, 0x90, 0x04.
- R2: The second select window carries exactly five bytes on MOSI: 0x60, then 0x00 four times.
- R3: Chip select stays high between the two windows. It falls for the read window exactly `WAIT_CYCLES` clock cycles after it rose at the end of the configuration window.
- R4: Mode 0 with MSB first. SCLK is low whenever chip select is high, and MOSI never changes while SCLK is high.
- R5: `count` equals the four bytes received during the filler bytes, packed with the first received byte in bits 31:24. The byte received during the 0x60 command is discarded.
- R6: `count_valid` is a single-cycle pulse that follows the release of chip select after the read window. `count` changes only in that cycle and holds its value otherwise.
- R7: Chip select falls at least `HALF_DIV` clock cycles before the first SCLK rising edge of a window. It rises at least `HALF_DIV` clock cycles after the last SCLK falling edge.
- R8: `busy` is high from the cycle after an accepted `start` until the `count_valid` cycle. A `start` that arrives while `busy` is high starts nothing.
- R9: After reset, `cs_n` is high, `sclk` is low, `busy` and `count_valid` are low, and `count` is zero.
- R10: Inside a window, SCLK stays high for exactly `HALF_DIV` clock cycles and low for exactly `HALF_DIV` clock cycles between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins the script when the block is idle |
| busy | output | 1 | High while the script is running |
| sclk | output | 1 | SPI serial clock |
| mosi | output | 1 | SPI data from the master |
| cs_n | output | 1 | Active-low chip select |
| miso | input | 1 | SPI data from the remote counter |
| count | output | 32 | Last count that was read |
| count_valid | output | 1 | One-cycle strobe when `count` is updated |

## Verification
The in-RTL assertions check these properties on every cycle:
- SCLK is low while chip select is high.
- MOSI is stable while SCLK is high.
- Chip select only moves while SCLK is low.
- The strobe lasts a single cycle, and `count` changes only in that cycle.
- `busy` follows an accepted start.

Some behaviour can only be shown by the bench scenarios, using a modelled remote counter:
- the byte content and byte count of each window;
- the exact half-period spacing and the lead and tail margins;
- the length of the pause;
- correct packing of the returned count, with the command-time reply discarded;
- start pulses issued mid-run having no effect.

// File: rtl/spi_cnt_seq.sv
module spi_cnt_seq #(
  parameter int HALF_DIV    = 25,
  parameter int WAIT_CYCLES = 100_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        busy,
  output logic        sclk,
  output logic        mosi,
  output logic        cs_n,
  input  logic        miso,
  output logic [31:0] count,
  output logic        count_valid
);

  localparam int HW = $clog2(HALF_DIV + 1);
  localparam int WW = $clog2(WAIT_CYCLES + 1);
  localparam logic [2:0] CFG_LAST = 3'd3;
  localparam logic [2:0] RD_LAST  = 3'd4;

  typedef enum logic [2:0] {IDLE, LEAD, XFER, TAIL, GAP} st_t;

  st_t           state;
  logic          rd;
  logic [HW-1:0] hcnt;
  logic [WW-1:0] wcnt;
  logic [2:0]    bcnt, bidx;
  logic [7:0]    tx, rx;
  logic [31:0]   sh;
  logic          tick;

  function automatic logic [7:0] script(input logic rd_win, input logic [2:0] idx);
    if (rd_win) return (idx == 3'd0) ? 8'h60 : 8'h00;
    case (idx)
      3'd0:    return 8'h88;
      3'd1:    return 8'h03;
      3'd2:    return 8'h90;
      default: return 8'h04;
    endcase
  endfunction

  assign tick = (hcnt == HW'(HALF_DIV - 1));
  assign busy = (state != IDLE);
  assign mosi = cs_n ? 1'b0 : tx[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= IDLE;
      rd          <= 1'b0;
      hcnt        <= '0;
      wcnt        <= '0;
      bcnt        <= '0;
      bidx        <= '0;
      tx          <= '0;
      rx          <= '0;
      sh          <= '0;
      sclk        <= 1'b0;
      cs_n        <= 1'b1;
      count       <= '0;
      count_valid <= 1'b0;
    end else begin
      count_valid <= 1'b0;
      hcnt <= (state == IDLE || state == GAP || tick) ? '0 : hcnt + 1'b1;
      case (state)
        IDLE: if (start) begin
          state <= LEAD;
          rd    <= 1'b0;
          cs_n  <= 1'b0;
          bidx  <= '0;
          bcnt  <= '0;
          tx    <= script(1'b0, 3'd0);
        end
        LEAD: if (tick) state <= XFER;
        XFER: if (tick) begin
          if (!sclk) begin
            sclk <= 1'b1;
            rx   <= {rx[6:0], miso};
          end else begin
            sclk <= 1'b0;
            if (bcnt == 3'd7) begin
              bcnt <= '0;
              if (rd && bidx != 3'd0) sh <= {sh[23:0], rx};
              if (bidx == (rd ? RD_LAST : CFG_LAST)) begin
                state <= TAIL;
              end else begin
                bidx <= bidx + 3'd1;
                tx   <= script(rd, bidx + 3'd1);
              end
            end else begin
              bcnt <= bcnt + 3'd1;
              tx   <= {tx[6:0], 1'b0};
            end
          end
        end
        TAIL: if (tick) begin
          cs_n <= 1'b1;
          if (rd) begin
            state       <= IDLE;
            count       <= sh;
            count_valid <= 1'b1;
          end else begin
            state <= GAP;
            wcnt  <= '0;
          end
        end
        GAP: begin
          if (wcnt == WW'(WAIT_CYCLES - 1)) begin
            state <= LEAD;
            rd    <= 1'b1;
            cs_n  <= 1'b0;
            bidx  <= '0;
            bcnt  <= '0;
            tx    <= script(1'b1, 3'd0);
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  // R4
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R4
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R7
  cs_edge_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != $past(cs_n)) |-> (!sclk && !$past(sclk)));

  // R6
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_valid |=> !count_valid);

  // R6
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> count_valid);

  // R8
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

endmodule

// File: tb/spi_cnt_seq_test.sv
module spi_cnt_seq_test;

  localparam int HALF = 3;
  localparam int WAITC = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic miso = 1'b0;
  logic busy, sclk, mosi, cs_n, count_valid;
  logic [31:0] count;

  int tests = 0, fails = 0;
  int cyc = 0;

  spi_cnt_seq #(.HALF_DIV(HALF), .WAIT_CYCLES(WAITC)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .sclk(sclk),
    .mosi(mosi), .cs_n(cs_n), .miso(miso), .count(count), .count_valid(count_valid)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int win, input int idx);
    if (win == 1) return (idx == 0) ? 8'h60 : 8'h00;
    case (idx)
      0: return 8'h88;
      1: return 8'h03;
      2: return 8'h90;
      default: return 8'h04;
    endcase
  endfunction

  logic [31:0] slv_val = '0;
  logic [7:0]  slv_junk = '0;
  logic [39:0] sreg = '0;
  logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_valid = 1'b0, mosi_at_rise = 1'b0;
  bit first_edge = 1'b0, in_txn = 1'b0;
  int win = 1, bits = 0, nbytes = 0;
  int t_csfall = 0, t_csrise = 0, t_rise = 0, t_fall = 0;
  logic [7:0] acc = '0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_cs && !cs_n) begin
        win = (win == 1) ? 0 : 1;
        if (win == 1) chk((cyc - t_csrise) == WAITC, "R3 wait length", cyc - t_csrise, WAITC);
        bits = 0; nbytes = 0; first_edge = 1'b1; t_csfall = cyc;
        sreg = {slv_junk, slv_val};
        miso = sreg[39];
      end
      if (cs_n && sclk) chk(1'b0, "R4 sclk high while deselected", 1, 0);
      if (!prev_sclk && sclk) begin
        if (first_edge) chk((cyc - t_csfall) >= HALF, "R7 lead", cyc - t_csfall, HALF);
        else chk((cyc - t_fall) == HALF, "R10 low phase", cyc - t_fall, HALF);
        first_edge = 1'b0;
        t_rise = cyc;
        mosi_at_rise = mosi;
        acc = {acc[6:0], mosi};
        bits++;
        if (bits == 8) begin
          chk(acc == exp_byte(win, nbytes), win ? "R2 read byte" : "R1 config byte", acc, exp_byte(win, nbytes));
          nbytes++;
          bits = 0;
        end
      end else if (sclk && mosi != mosi_at_rise) begin
        chk(1'b0, "R4 mosi moved while sclk high", mosi, mosi_at_rise);
      end
      if (prev_sclk && !sclk) begin
        chk((cyc - t_rise) == HALF, "R10 high phase", cyc - t_rise, HALF);
        t_fall = cyc;
        sreg = sreg << 1;
        miso = sreg[39];
      end
      if (!prev_cs && cs_n) begin
        chk((cyc - t_fall) >= HALF, "R7 tail", cyc - t_fall, HALF);
        chk(nbytes == (win ? 5 : 4), win ? "R2 byte count" : "R1 byte count", nbytes, win ? 5 : 4);
        t_csrise = cyc;
      end
      if (prev_valid && count_valid) chk(1'b0, "R6 strobe longer than one cycle", 1, 0);
      if (busy) in_txn = 1'b1;
      if (count_valid) in_txn = 1'b0;
      else if (in_txn && !busy) begin
        chk(1'b0, "R8 busy dropped early", 0, 1);
        in_txn = 1'b0;
      end
    end
    prev_cs = cs_n; prev_sclk = sclk; prev_valid = count_valid;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic run(input logic [31:0] val, input bit poke);
    int lim;
    @(negedge clk);
    slv_val = val;
    slv_junk = 8'($urandom);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R8 busy after start", busy, 1);
    if (poke) begin
      repeat (120) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    lim = 0;
    while (!count_valid && lim < 5000) begin
      @(negedge clk);
      lim++;
    end
    chk(count_valid == 1'b1, "R6 strobe seen", count_valid, 1);
    chk(count == val, "R5 assembled count", count, val);
    @(negedge clk);
    chk(!count_valid && count == val, "R6 count held", count, val);
    if (poke) begin
      for (int i = 0; i < 30; i++) begin
        if (!cs_n || busy) begin
          chk(1'b0, "R8 start while busy restarted", busy, 0);
          break;
        end
        @(negedge clk);
      end
      chk(cs_n && !busy, "R8 idle after ignored start", busy, 0);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0, "R9 reset pins", {cs_n, sclk}, 2'b10);
    chk(!busy && !count_valid && count == 32'd0, "R9 reset outputs", count, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run(32'h0000_0000, 1'b0);
    run(32'hFFFF_FFFF, 1'b1);
    run(32'h8000_0001, 1'b0);
    run(32'hA5A5_5A5A, 1'b1);
    for (int k = 0; k < 8; k++) run($urandom, k[0]);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule